// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is the clocked command and address register of a memory module. On each rising clock edge it captures a bank of input bits and presents them on registered outputs. Two static mode inputs choose how the register is shaped. In the wide shape every input bit drives one output. In the split shape a smaller set of captured bits each drives two identical output copies, A and B, and one of two input-to-slot layouts applies.

Two active-low select inputs control whether the data outputs may change. The registered select outputs always follow the captured select input. An asynchronous active-low reset clears every register at once and takes priority over the select gating. Tying `csr_n` low turns `dcs_n` into an ordinary captured bit.

Top module: `rbuf_cmd_reg`

## Requirements
- R1: In wide mode (`mode_split`=0), one rising edge after `din` is presented, `q_a[i]` equals `din[i]` for all 25 bits.
- R2: In wide mode, `q_b` and `qcs_b` are driven low.
- R3: In split layout A (`mode_split`=1, `mode_alt`=0), slot k (0..12) takes `din[k]`. Both `q_a[k]` and `q_b[k]` carry it, and `q_a[24:13]` are low.
- R4: In split layout B (`mode_split`=1, `mode_alt`=1), slot 0 takes `din[13]`, slot 3 takes `din[14]`, slot 9 takes `din[3]` and slot 12 takes `din[0]`. Every other slot k takes `din[k]`, and both copies carry the slot.
- R5: `mode_split`=0 with `mode_alt`=1 behaves exactly like wide mode.
- R6: When `dcs_n` and `csr_n` are both high at a rising edge, `q_a` and `q_b` keep their previous values.
- R7: When either `dcs_n` or `csr_n` is low at a rising edge, the data outputs load the routed inputs.
- R8: `qcs_a` (and `qcs_b` in split mode) takes the value `dcs_n` had at each rising edge, whatever the gating.
- R9: A falling `rst_n` drives all outputs low at once, without a clock edge.
- R10: While `rst_n` is low, the outputs stay low regardless of the selects. The first rising edge after release loads fresh data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_split | input | 1 | 0: wide one-to-one, 1: split one-to-two |
| mode_alt | input | 1 | Split layout choice: 0 layout A, 1 layout B |
| dcs_n | input | 1 | Active-low chip select, also captured |
| csr_n | input | 1 | Second active-low select |
| din | input | 25 | Command/address input bits |
| q_a | output | 25 | Registered outputs, copy A |
| q_b | output | 13 | Registered outputs, copy B (split mode) |
| qcs_a | output | 1 | Registered chip select, copy A |
| qcs_b | output | 1 | Registered chip select, copy B (split mode) |

## Verification
Every data and select result appears one rising edge after the stimulus is captured. The bench drives inputs on the falling edge and reads the outputs on the falling edge that follows the next rising edge. The reset clear has no latency: the bench lowers `rst_n` in the low half of the clock and reads the outputs a nanosecond later, before any rising edge. The check for the first load after release is made exactly one edge after `rst_n` rises, which confirms that no extra cycle is inserted.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;

    typedef enum logic [1:0] {
        MAP_WIDE    = 2'd0,
        MAP_SPLIT_A = 2'd1,
        MAP_SPLIT_B = 2'd2
    } map_e;

    function automatic map_e decode_map(input logic split, input logic alt);
        if (!split)   return MAP_WIDE;
        else if (alt) return MAP_SPLIT_B;
        else          return MAP_SPLIT_A;
    endfunction

    // Source input index of a slot in split layout B.
    function automatic int alt_src(input int slot, input int split_w);
        if (slot == 0)           return split_w;
        if (slot == 3)           return split_w + 1;
        if (slot == split_w - 4) return 3;
        if (slot == split_w - 1) return 0;
        return slot;
    endfunction

endpackage

// File: rtl/rbuf_route.sv
module rbuf_route #(
    parameter int WIDE_W  = 25,
    parameter int SPLIT_W = 13
) (
    input  logic               mode_split,
    input  logic               mode_alt,
    input  logic               dcs_n,
    input  logic [WIDE_W-1:0]  din,
    output logic [WIDE_W-1:0]  route_a,
    output logic [SPLIT_W-1:0] route_b,
    output logic               cs_a,
    output logic               cs_b
);
    localparam int PAD_W = WIDE_W - SPLIT_W;

    rbuf_pkg::map_e map_sel;
    logic [SPLIT_W-1:0] slot_a;
    logic [SPLIT_W-1:0] slot_b;

    assign map_sel = rbuf_pkg::decode_map(mode_split, mode_alt);

    for (genvar k = 0; k < SPLIT_W; k++) begin : g_slot
        localparam int SRC_B = rbuf_pkg::alt_src(k, SPLIT_W);
        assign slot_a[k] = din[k];
        assign slot_b[k] = din[SRC_B];
    end

    always_comb begin
        route_a = '0;
        route_b = '0;
        cs_a    = dcs_n;
        cs_b    = 1'b0;
        unique case (map_sel)
            rbuf_pkg::MAP_SPLIT_A: begin
                route_a = {{PAD_W{1'b0}}, slot_a};
                route_b = slot_a;
                cs_b    = dcs_n;
            end
            rbuf_pkg::MAP_SPLIT_B: begin
                route_a = {{PAD_W{1'b0}}, slot_b};
                route_b = slot_b;
                cs_b    = dcs_n;
            end
            default: begin
                route_a = din;
            end
        endcase
    end
endmodule

// File: rtl/rbuf_gate.sv
module rbuf_gate (
    input  logic dcs_n,
    input  logic csr_n,
    output logic load_en
);
    // Data may update unless both selects are inactive.
    always_comb load_en = ~(dcs_n & csr_n);
endmodule

// File: rtl/rbuf_cmd_reg.sv
module rbuf_cmd_reg #(
    parameter int WIDE_W  = 25,
    parameter int SPLIT_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_split,
    input  logic               mode_alt,
    input  logic               dcs_n,
    input  logic               csr_n,
    input  logic [WIDE_W-1:0]  din,
    output logic [WIDE_W-1:0]  q_a,
    output logic [SPLIT_W-1:0] q_b,
    output logic               qcs_a,
    output logic               qcs_b
);
    typedef struct packed {
        logic [WIDE_W-1:0]  a;
        logic [SPLIT_W-1:0] b;
        logic               csa;
        logic               csb;
    } reg_t;

    reg_t st_d, st_q;

    logic [WIDE_W-1:0]  route_a;
    logic [SPLIT_W-1:0] route_b;
    logic               cs_a, cs_b, load_en;

    rbuf_route #(.WIDE_W(WIDE_W), .SPLIT_W(SPLIT_W)) u_route (
        .mode_split (mode_split),
        .mode_alt   (mode_alt),
        .dcs_n      (dcs_n),
        .din        (din),
        .route_a    (route_a),
        .route_b    (route_b),
        .cs_a       (cs_a),
        .cs_b       (cs_b)
    );

    rbuf_gate u_gate (
        .dcs_n   (dcs_n),
        .csr_n   (csr_n),
        .load_en (load_en)
    );

    always_comb begin
        st_d     = st_q;
        st_d.csa = cs_a;
        st_d.csb = cs_b;
        if (load_en) begin
            st_d.a = route_a;
            st_d.b = route_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_a   = st_q.a;
    assign q_b   = st_q.b;
    assign qcs_a = st_q.csa;
    assign qcs_b = st_q.csb;

    // R6
    hold_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dcs_n && csr_n) |=> ($stable(q_a) && $stable(q_b)));

    // R8
    cs_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (qcs_a == $past(dcs_n)));

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0 && !qcs_a && !qcs_b));

    // R2
    wide_b_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_split |-> (q_b == '0 && !qcs_b));

    // R3
    split_copies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_split |-> (q_a[SPLIT_W-1:0] == q_b && q_a[WIDE_W-1:SPLIT_W] == '0
                        && qcs_a == qcs_b));
endmodule

// File: tb/tb_rbuf_cmd_reg.sv
module tb_rbuf_cmd_reg;
    localparam int W = 25;
    localparam int S = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_split = 1'b0, mode_alt = 1'b0;
    logic         dcs_n = 1'b1, csr_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] q_a;
    logic [S-1:0] q_b;
    logic         qcs_a, qcs_b;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rbuf_cmd_reg dut (
        .clk(clk), .rst_n(rst_n), .mode_split(mode_split), .mode_alt(mode_alt),
        .dcs_n(dcs_n), .csr_n(csr_n), .din(din),
        .q_a(q_a), .q_b(q_b), .qcs_a(qcs_a), .qcs_b(qcs_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Independent model of the slot layouts.
    function automatic logic [S-1:0] slots(input logic [W-1:0] d, input logic alt);
        logic [S-1:0] r;
        for (int k = 0; k < S; k++) r[k] = d[k];
        if (alt) begin
            r[0]  = d[13];
            r[3]  = d[14];
            r[9]  = d[3];
            r[12] = d[0];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] exp_a(input logic [W-1:0] d);
        if (!mode_split) return d;
        return {{(W-S){1'b0}}, slots(d, mode_alt)};
    endfunction

    function automatic logic [S-1:0] exp_b(input logic [W-1:0] d);
        if (!mode_split) return '0;
        return slots(d, mode_alt);
    endfunction

    task automatic apply(input logic [W-1:0] d, input logic cs, input logic cr);
        @(negedge clk);
        din = d; dcs_n = cs; csr_n = cr;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic sp, input logic al);
        @(negedge clk);
        rst_n = 1'b0; mode_split = sp; mode_alt = al;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk("R9 reset q_a", 32'(q_a), 32'h0);
        chk("R9 reset q_b", 32'(q_b), 32'h0);
        chk("R9 reset cs", {30'd0, qcs_a, qcs_b}, 32'h0);
    endtask

    task automatic t_wide(input logic al, input string req);
        logic [W-1:0] p [3];
        p[0] = 25'h1AB_CDEF; p[1] = 25'h0F0_F0F0; p[2] = 25'h155_5555;
        set_mode(1'b0, al);
        for (int i = 0; i < 3; i++) begin
            apply(p[i], 1'b0, 1'b1);
            chk({req, " wide q_a"}, 32'(q_a), 32'(p[i]));
            chk("R2 wide q_b low", {18'd0, q_b, qcs_b}, 32'h0);
        end
    endtask

    task automatic t_split(input logic al, input string req);
        logic [W-1:0] p [4];
        p[0] = 25'h000_2001; p[1] = 25'h000_6008; p[2] = 25'h1FF_FFFF; p[3] = 25'h0AA_5A5A;
        set_mode(1'b1, al);
        for (int i = 0; i < 4; i++) begin
            apply(p[i], 1'b0, 1'b0);
            chk({req, " q_a"}, 32'(q_a), 32'(exp_a(p[i])));
            chk({req, " q_b"}, 32'(q_b), 32'(exp_b(p[i])));
        end
    endtask

    task automatic t_gating;
        logic [W-1:0] p1 = 25'h123_4567, p2 = 25'h0DE_AD00, p3 = 25'h1C3_3C3C;
        apply(p1, 1'b0, 1'b1);
        chk("R7 dcs low loads q_a", 32'(q_a), 32'(exp_a(p1)));
        chk("R8 qcs_a follows dcs", {31'd0, qcs_a}, 32'h0);
        apply(p2, 1'b1, 1'b1);
        chk("R6 both high holds q_a", 32'(q_a), 32'(exp_a(p1)));
        chk("R6 both high holds q_b", 32'(q_b), 32'(exp_b(p1)));
        chk("R8 qcs_a updates when gated", {31'd0, qcs_a}, 32'h1);
        chk("R8 qcs_b", {31'd0, qcs_b}, {31'd0, mode_split});
        apply(p3, 1'b1, 1'b0);
        chk("R7 csr low loads q_a", 32'(q_a), 32'(exp_a(p3)));
        chk("R8 qcs_a with csr low", {31'd0, qcs_a}, 32'h1);
    endtask

    task automatic t_async_reset;
        logic [W-1:0] p = 25'h17F_00FF;
        apply(25'h1FF_FFFF, 1'b0, 1'b0);
        #5 rst_n = 1'b0;
        #1;
        chk("R9 async clear q_a", 32'(q_a), 32'h0);
        chk("R9 async clear q_b", 32'(q_b), 32'h0);
        apply(25'h1FF_FFFF, 1'b0, 1'b0);
        chk("R10 reset priority q_a", 32'(q_a), 32'h0);
        chk("R10 reset priority cs", {31'd0, qcs_a}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1; din = p; dcs_n = 1'b0; csr_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 first edge loads", 32'(q_a), 32'(exp_a(p)));
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: all requirements, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_wide(1'b0, "R1");
        t_gating();
        t_wide(1'b1, "R5");
        t_split(1'b0, "R3");
        t_gating();
        t_split(1'b1, "R4");
        t_gating();
        set_mode(1'b0, 1'b0);
        t_async_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule